// File: doc/BRIEF.md
# Combinational Integer ALU with Signed Less-Than

A 32-bit arithmetic-logic unit with no clock or reset. Each cycle it takes two operands and a 3-bit function code. It returns a result word and three flags: carry out of the top bit, zero result, and signed overflow. The functions are bitwise AND, bitwise OR, addition, subtraction and a signed less-than compare.

Inside, a chain of one-bit slices is linked by a ripple carry. Each slice computes AND, OR and a full-adder sum in parallel, and a 4-way mux picks one of them or an externally supplied "less" bit. The top bit of the function code does two jobs. It inverts B in every slice and it is also the carry into bit 0, so subtraction and the compare reuse the same adder. The compare bit is built from the sign of A, the sign of B and the sign of the difference, so it stays correct when the difference overflows. Overflow is only a flag and never traps.

Top module: `int_alu`

## Requirements
- R1: Code 3'b000 gives result = A AND B, with carry_out = 0 and overflow = 0.
- R2: Code 3'b001 gives result = A OR B, with carry_out = 0 and overflow = 0.
- R3: Code 3'b010 gives result = A + B modulo 2^32. carry_out is the carry leaving bit 31 of that sum.
- R4: Code 3'b110 gives result = A + ~B + 1, which is A - B. carry_out is the carry leaving bit 31, and it is 1 exactly when A >= B as unsigned numbers.
- R5: Code 3'b111 gives result bit 0 = 1 when A < B as signed two's-complement values, and bits 31..1 = 0. The compare is correct even when A - B overflows.
- R6: For code 3'b010, overflow = 1 exactly when A and B have equal sign bits and the sum's sign bit differs from them.
- R7: For codes 3'b110 and 3'b111, overflow = 1 exactly when A and B have unequal sign bits and the difference's sign bit differs from A's sign bit. For 3'b111, carry_out is the carry of that subtraction.
- R8: zero = 1 exactly when all 32 result bits are 0.
- R9: Codes 3'b011, 3'b100 and 3'b101 are undefined. They give result = 0, carry_out = 0, overflow = 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| func_sel | input | 3 | Function code; bit 2 is B-invert and carry into bit 0 |
| result | output | 32 | Function result |
| carry_out | output | 1 | Carry leaving bit 31 for arithmetic codes, else 0 |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the add or the subtract |

## Verification
The block holds no state, so any internal fault shows at the ports for the same input vector that exercises it.

- A broken carry link corrupts the sum bits above it and carry_out whenever a carry must travel through it.
- A wrong B-invert or a wrong carry into bit 0 shifts the subtract and compare results by one, or flips them.
- A bad sign-selection term in the less-than logic appears only in the compares where the difference overflows.

For this reason the stimulus forces overflow with operands at the extremes of the signed range, and adds pseudo-random vectors under all eight codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } alu_fn_e;

  // slice mux selections (low two function bits)
  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

  function automatic logic fn_defined(input logic [FUNC_W-1:0] f);
    return (f == FN_AND) || (f == FN_OR) || (f == FN_ADD) ||
           (f == FN_SUB) || (f == FN_SLT);
  endfunction

  function automatic logic fn_arith(input logic [FUNC_W-1:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_SLT);
  endfunction
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       b_inv_i,
  input  logic       c_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       c_o,
  output logic       sign_o
);
  logic b_eff;
  logic sum;

  assign b_eff = b_inv_i ? ~b_i : b_i;
  assign sum   = a_i ^ b_eff ^ c_i;
  assign c_o   = (a_i & b_eff) | (a_i & c_i) | (b_eff & c_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum;
      default:  res_o = less_i;
    endcase
  end

  // only the top slice reports its raw sum bit (sign of the adder output)
  generate
    if (IS_TOP) begin : g_top
      assign sign_o = sum;
    end else begin : g_mid
      assign sign_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit (
  input  logic sa_i,
  input  logic sb_i,
  input  logic sr_i,
  output logic less_o,
  output logic ovf_add_o,
  output logic ovf_sub_o
);
  // signs differ: A negative means A is smaller; otherwise the difference sign decides
  assign less_o    = (sa_i ^ sb_i) ? sa_i : sr_i;
  assign ovf_add_o = ~(sa_i ^ sb_i) & (sr_i ^ sa_i);
  assign ovf_sub_o =  (sa_i ^ sb_i) & (sr_i ^ sa_i);
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic         zero_o
);
  localparam int unsigned LVLS = (W <= 1) ? 1 : $clog2(W);
  localparam int unsigned PW   = 1 << LVLS;

  logic [PW-1:0] padded;
  logic [2*PW-2:0] node;

  assign padded = {{(PW-W){1'b0}}, vec_i};

  // balanced OR tree: leaves at node[PW-1 +: PW], root at node[0]
  generate
    for (genvar k = 0; k < PW; k++) begin : g_leaf
      assign node[PW-1+k] = padded[k];
    end
    for (genvar n = 0; n < PW-1; n++) begin : g_or
      assign node[n] = node[2*n+1] | node[2*n+2];
    end
  endgenerate

  assign zero_o = ~node[0];
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic [2:0]        func_sel,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out,
  output logic              zero,
  output logic              overflow
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] sign_bits;
  logic             top_sum;
  logic             less_bit;
  logic             ovf_add;
  logic             ovf_sub;
  logic             fn_ok;
  logic             fn_ar;

  assign carry[0] = func_sel[2];

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_bit_slice #(
        .IS_TOP (i == MSB)
      ) u_slice (
        .a_i     (opnd_a[i]),
        .b_i     (opnd_b[i]),
        .b_inv_i (func_sel[2]),
        .c_i     (carry[i]),
        .less_i  ((i == 0) ? less_bit : 1'b0),
        .sel_i   (func_sel[1:0]),
        .res_o   (slice_res[i]),
        .c_o     (carry[i+1]),
        .sign_o  (sign_bits[i])
      );
    end
  endgenerate

  assign top_sum = |sign_bits;

  alu_sign_unit u_sign (
    .sa_i      (opnd_a[MSB]),
    .sb_i      (opnd_b[MSB]),
    .sr_i      (top_sum),
    .less_o    (less_bit),
    .ovf_add_o (ovf_add),
    .ovf_sub_o (ovf_sub)
  );

  assign fn_ok = fn_defined(func_sel);
  assign fn_ar = fn_arith(func_sel);

  assign result    = fn_ok ? slice_res : '0;
  assign carry_out = fn_ar & carry[WIDTH];

  always_comb begin
    if (func_sel == FN_ADD)
      overflow = ovf_add;
    else if (func_sel == FN_SUB || func_sel == FN_SLT)
      overflow = ovf_sub;
    else
      overflow = 1'b0;
  end

  alu_zero_detect #(.W(WIDTH)) u_zero (
    .vec_i  (result),
    .zero_o (zero)
  );
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       func_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero,
  input logic             overflow
);
  logic [WIDTH:0] wide_add;
  logic [WIDTH:0] wide_sub;
  logic           sa, sb;

  assign wide_add = {1'b0, opnd_a} + {1'b0, opnd_b};
  assign wide_sub = {1'b0, opnd_a} + {1'b0, ~opnd_b} + {{WIDTH{1'b0}}, 1'b1};
  assign sa = opnd_a[WIDTH-1];
  assign sb = opnd_b[WIDTH-1];

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, func_sel})) begin
      if (func_sel == 3'b000)
        AST_AND_FN: assert (result == (opnd_a & opnd_b) && !carry_out && !overflow); // R1
      if (func_sel == 3'b001)
        AST_OR_FN: assert (result == (opnd_a | opnd_b) && !carry_out && !overflow); // R2
      if (func_sel == 3'b010)
        AST_ADD_FN: assert (result == wide_add[WIDTH-1:0] && carry_out == wide_add[WIDTH]); // R3
      if (func_sel == 3'b110)
        AST_SUB_FN: assert (result == opnd_a - opnd_b && carry_out == (opnd_a >= opnd_b)); // R4
      if (func_sel == 3'b111)
        AST_SLT_FN: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))}); // R5
      if (func_sel == 3'b010)
        AST_ADD_OVF: assert (overflow == ((sa == sb) && (wide_add[WIDTH-1] != sa))); // R6
      if (func_sel == 3'b110 || func_sel == 3'b111)
        AST_SUB_OVF: assert (overflow == ((sa != sb) && (wide_sub[WIDTH-1] != sa)) && carry_out == wide_sub[WIDTH]); // R7
      AST_ZERO_FLAG: assert (zero == (result == '0)); // R8
      if (func_sel == 3'b011 || func_sel == 3'b100 || func_sel == 3'b101)
        AST_UNDEF_FN: assert (result == '0 && !carry_out && !overflow && zero); // R9
    end
  end
endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) u_int_alu_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .func_sel  (func_sel),
  .result    (result),
  .carry_out (carry_out),
  .zero      (zero),
  .overflow  (overflow)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] res;
    logic         c;
    logic         z;
    logic         v;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   f = 3'b000;
  logic [W-1:0] result;
  logic         carry_out, zero, overflow;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  int_alu #(.WIDTH(W)) dut (
    .opnd_a(a), .opnd_b(b), .func_sel(f),
    .result(result), .carry_out(carry_out), .zero(zero), .overflow(overflow)
  );

  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                 input logic [2:0] fn);
    exp_t e;
    logic [W:0] s;
    e = '0;
    case (fn)
      3'b000: e.res = x & y;                          // R1
      3'b001: e.res = x | y;                          // R2
      3'b010: begin                                   // R3, R6
        s = {1'b0, x} + {1'b0, y};
        e.res = s[W-1:0];
        e.c   = s[W];
        e.v   = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      3'b110, 3'b111: begin                           // R4, R5, R7
        s = {1'b0, x} + {1'b0, ~y} + 1;
        e.c = s[W];
        e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
        if (fn == 3'b110) e.res = s[W-1:0];
        else e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      end
      default: e.res = '0;                            // R9
    endcase
    e.z = (e.res == '0);                              // R8
    return e;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [2:0] fn, input string tag);
    @(posedge clk);
    a = x; b = y; f = fn;
    exp_q.push_back(model(x, y, fn));
    tag_q.push_back(tag);
  endtask

  // monitor: compare half a period after each drive
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (result !== e.res || carry_out !== e.c || zero !== e.z || overflow !== e.v) begin
        bad++;
        $display("FAIL %s: f=%b a=%h b=%h got res=%h c=%b z=%b v=%b exp res=%h c=%b z=%b v=%b",
                 t, f, a, b, result, carry_out, zero, overflow, e.res, e.c, e.z, e.v);
      end
    end
  end

  initial begin
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, got cycle=%0d exp completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: all-zero inputs, AND -> 0, zero flag set (R1, R8)
    drive('0, '0, 3'b000, "R1 idle");
    drive(32'hF0F0_1234, 32'hFF00_FF0F, 3'b000, "R1 and");
    drive(32'hF0F0_1234, 32'h0F00_0000, 3'b001, "R2 or");
    drive(32'h0000_0005, 32'h0000_0007, 3'b010, "R3 add");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R3 R8 wrap to zero with carry");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R6 pos overflow");
    drive(32'h8000_0000, 32'h8000_0000, 3'b010, "R6 neg overflow");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b010, "R6 mixed no overflow");
    drive(32'h0000_0009, 32'h0000_0009, 3'b110, "R4 R8 equal sub");
    drive(32'h0000_0003, 32'h0000_0009, 3'b110, "R4 borrow");
    drive(32'h8000_0000, 32'h0000_0001, 3'b110, "R7 sub overflow");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R7 sub overflow pos");
    drive(32'h8000_0000, 32'h0000_0001, 3'b111, "R5 slt min vs 1 overflowing");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, "R5 slt max vs min overflowing");
    drive(32'hFFFF_FFFE, 32'hFFFF_FFFF, 3'b111, "R5 slt -2 vs -1");
    drive(32'h0000_0004, 32'h0000_0004, 3'b111, "R5 slt equal");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R9 code 011");
    drive(32'hFFFF_FFFF, 32'h1234_5678, 3'b100, "R9 code 100");
    drive(32'h8000_0001, 32'h7FFF_FFFF, 3'b101, "R9 code 101");
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 320; k++) begin
      logic [W-1:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = (k % 5 == 0) ? {x[31], ~x[30:0]} : lfsr;
      drive(x, y, k[2:0], "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule